// File: doc/BRIEF.md
# Randomized Reaction Timer

This block times how fast a person answers a light. A Start press begins a wait of random length. When the wait ends the stimulus LED turns on, and the block counts whole milliseconds until Stop is pressed. The wait length comes from a free-running pseudo-random register, so the exact clock cycle of the Start press sets the delay. Pressing Stop too early is reported as a false start. If nobody presses Stop, the count saturates at a ceiling.

Every valid result is kept in one of a set of holding registers. When the last register of the set is filled, the block publishes the mean of the set and raises a one-cycle strobe. The result and the mean are plain binary values for a separate display driver. The three button inputs must already be debounced, synchronized and reduced to single-cycle pulses. The millisecond tick is a clock-count parameter, so a bench can run the block fast.

Top module: `reaction_timer`

## Requirements
- R1: After reset the LED is off, the result, the average and the false-start flag are 0, and the average strobe is low.
- R2: A Start pulse in the idle state sets the result to 0 and begins a random wait. A Start pulse while waiting, timing, or flagged has no effect.
- R3: The wait is a whole number of milliseconds between MIN_WAIT_MS and MIN_WAIT_MS+SPAN_MS. It is derived from a 16-bit maximal-length LFSR. The LED turns on exactly when the wait ends.
- R4: While the LED is on, a Stop pulse captures the number of whole milliseconds elapsed since the LED turned on, turns the LED off and returns to idle. A Stop pulse in idle leaves the result unchanged.
- R5: A Stop pulse during the wait sets the false-start flag and drives the result to all ones (1023 with a 10-bit result). This state persists, and Start is ignored, until Clear.
- R6: If no Stop arrives within MAX_MS milliseconds of the LED turning on, the result becomes MAX_MS and the LED turns off after exactly MAX_MS ticks.
- R7: Each captured or saturated result fills the next of TRIALS holding registers. One cycle after the last register is filled, the average output shows floor(sum/TRIALS) and the average strobe is high for exactly one cycle. Filling then restarts at the first register.
- R8: Clear, from any state, returns to idle with the LED off, the result at 0, the false-start flag low, the average at 0 and all stored results discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startBtn | input | 1 | Start pulse (one cycle) |
| stopBtn | input | 1 | Stop pulse (one cycle) |
| clearBtn | input | 1 | Clear pulse (one cycle) |
| stimulusLed | output | 1 | Stimulus light, high while timing |
| resultMs | output | RES_W | Last reaction time in ms, or all ones after a false start |
| falseStart | output | 1 | High after a premature Stop until Clear |
| averageMs | output | RES_W | Mean of the last full set of trials |
| averageValid | output | 1 | One-cycle strobe when averageMs updates |

## Verification
The assertions check several properties on every cycle. At most one control strobe is active at a time. The result never leaves the range 0..MAX_MS except for the error code. A false start is sticky until Clear. A freshly drawn wait lies inside its window. The average strobe never lasts two cycles. Clear always lands in idle.

Other properties depend on counting across whole trials, so only the bench scenarios can show them. These are the exact millisecond count captured at a given Stop instant and the exact saturation instant. They also include the value of the mean after a full set of trials, and the restart of the set after a Clear.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_STIM  = 2'd2,
    ST_FALSE = 2'd3
  } rtState_t;

  // control -> datapath
  typedef struct packed {
    logic armWait;     // draw a delay and start waiting
    logic beginStim;   // start millisecond count
    logic captureMs;   // record current count
    logic captureMax;  // record saturation value
    logic markFalse;   // premature stop
    logic wipe;        // clear everything
  } rtStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic waitDone;
    logic msLimit;
  } rtStatus_t;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/rt_ctrl.sv
module rt_ctrl
  import rt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startBtn,
  input  logic      stopBtn,
  input  logic      clearBtn,
  input  rtStatus_t status,
  output rtStrobe_t strobe,
  output logic      stimulusLed
);

  rtState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (clearBtn) begin
      strobe.wipe = 1'b1;
      stateNext   = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (startBtn) begin
          strobe.armWait = 1'b1;
          stateNext      = ST_WAIT;
        end
        ST_WAIT: if (stopBtn) begin
          strobe.markFalse = 1'b1;
          stateNext        = ST_FALSE;
        end else if (status.waitDone) begin
          strobe.beginStim = 1'b1;
          stateNext        = ST_STIM;
        end
        ST_STIM: if (stopBtn) begin
          strobe.captureMs = 1'b1;
          stateNext        = ST_IDLE;
        end else if (status.msLimit) begin
          strobe.captureMax = 1'b1;
          stateNext         = ST_IDLE;
        end
        ST_FALSE: stateNext = ST_FALSE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign stimulusLed = (state == ST_STIM);

  // R8: clear always lands in idle
  a_r8_clear_idle: assert property (@(posedge clk) disable iff (!rstN)
    clearBtn |=> (state == ST_IDLE));

  // R4: stop while timing ends the stimulus
  a_r4_stop_ends_stim: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STIM && stopBtn && !clearBtn) |=> !stimulusLed);

  // R3: at most one action strobe per cycle
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.armWait, strobe.beginStim, strobe.captureMs,
              strobe.captureMax, strobe.markFalse}));

endmodule

// File: rtl/rt_datapath.sv
module rt_datapath
  import rt_pkg::*;
#(
  parameter int TICK_DIV    = 50000,
  parameter int MIN_WAIT_MS = 1000,
  parameter int SPAN_MS     = 9000,
  parameter int MAX_MS      = 1000,
  parameter int TRIALS      = 8,
  localparam int RES_W      = $clog2(MAX_MS + 2)
)(
  input  logic             clk,
  input  logic             rstN,
  input  rtStrobe_t        strobe,
  output rtStatus_t        status,
  output logic [RES_W-1:0] resultMs,
  output logic             falseStart,
  output logic [RES_W-1:0] averageMs,
  output logic             averageValid
);

  localparam int DIV_W  = $clog2(TICK_DIV + 1);
  localparam int SPAN_W = $clog2(SPAN_MS + 2);
  localparam int PROD_W = LFSR_W + SPAN_W;
  localparam int WAIT_W = $clog2(MIN_WAIT_MS + SPAN_MS + 1);
  localparam int IDX_W  = (TRIALS > 1) ? $clog2(TRIALS) : 1;
  localparam int SHIFT  = $clog2(TRIALS);
  localparam int SUM_W  = RES_W + SHIFT;

  logic [LFSR_W-1:0] lfsr;
  logic [PROD_W-1:0] scaled;
  logic [WAIT_W-1:0] delayMs, waitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic              tick;
  logic [RES_W-1:0]  msCnt, captureVal;
  logic              capture, avgPend;
  logic [IDX_W-1:0]  trialIdx;
  logic [TRIALS-1:0][RES_W-1:0] hold;
  logic [SUM_W-1:0]  sum;

  // free-running maximal-length LFSR (x^16+x^14+x^13+x^11+1)
  always_ff @(posedge clk) begin
    if (!rstN) lfsr <= LFSR_SEED;
    else       lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  // map LFSR into 0..SPAN_MS by scaling, then offset
  assign scaled  = PROD_W'(lfsr) * PROD_W'(SPAN_MS + 1);
  assign delayMs = WAIT_W'(MIN_WAIT_MS) + WAIT_W'(scaled[PROD_W-1:LFSR_W]);

  // millisecond tick, realigned at each phase start
  assign tick = (divCnt == DIV_W'(TICK_DIV - 1));
  always_ff @(posedge clk) begin
    if (!rstN || strobe.wipe || strobe.armWait || strobe.beginStim) divCnt <= '0;
    else if (tick)                                                  divCnt <= '0;
    else                                                            divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.wipe)         waitCnt <= '0;
    else if (strobe.armWait)          waitCnt <= delayMs;
    else if (tick && waitCnt != '0)   waitCnt <= waitCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.wipe || strobe.beginStim)    msCnt <= '0;
    else if (tick && msCnt < RES_W'(MAX_MS))         msCnt <= msCnt + 1'b1;
  end

  assign status.waitDone = tick && (waitCnt == WAIT_W'(1));
  assign status.msLimit  = tick && (msCnt == RES_W'(MAX_MS - 1));

  assign capture    = strobe.captureMs | strobe.captureMax;
  assign captureVal = strobe.captureMax ? RES_W'(MAX_MS) : msCnt;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.wipe || strobe.armWait) resultMs <= '0;
    else if (strobe.markFalse)                  resultMs <= '1;
    else if (capture)                           resultMs <= captureVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.wipe) falseStart <= 1'b0;
    else if (strobe.markFalse) falseStart <= 1'b1;
  end

  // holding registers and trial index
  always_ff @(posedge clk) begin
    if (!rstN || strobe.wipe) begin
      hold     <= '0;
      trialIdx <= '0;
      avgPend  <= 1'b0;
    end else begin
      avgPend <= 1'b0;
      if (capture) begin
        for (int i = 0; i < TRIALS; i++)
          if (trialIdx == IDX_W'(i)) hold[i] <= captureVal;
        if (trialIdx == IDX_W'(TRIALS - 1)) begin
          trialIdx <= '0;
          avgPend  <= 1'b1;
        end else begin
          trialIdx <= trialIdx + 1'b1;
        end
      end
    end
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < TRIALS; i++) sum = sum + SUM_W'(hold[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.wipe) begin
      averageMs    <= '0;
      averageValid <= 1'b0;
    end else begin
      averageValid <= avgPend;
      if (avgPend) averageMs <= RES_W'(sum >> SHIFT);
    end
  end

  // R6: result stays within range or shows the error code
  a_r6_result_bound: assert property (@(posedge clk) disable iff (!rstN)
    (resultMs <= RES_W'(MAX_MS)) || (resultMs == '1));

  // R5: false-start flag is sticky until clear
  a_r5_false_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (falseStart && !strobe.wipe) |=> falseStart);

  // R7: average strobe lasts one cycle
  a_r7_avg_single: assert property (@(posedge clk) disable iff (!rstN)
    averageValid |=> !averageValid);

  // R2: arming the wait shows zero
  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.armWait |=> (resultMs == '0));

  // R3: drawn delay lies inside its window
  a_r3_wait_range: assert property (@(posedge clk) disable iff (!rstN)
    strobe.armWait |=> (waitCnt >= WAIT_W'(MIN_WAIT_MS)) &&
                       (waitCnt <= WAIT_W'(MIN_WAIT_MS + SPAN_MS)));

endmodule

// File: rtl/reaction_timer.sv
module reaction_timer
  import rt_pkg::*;
#(
  parameter int TICK_DIV    = 50000,
  parameter int MIN_WAIT_MS = 1000,
  parameter int SPAN_MS     = 9000,
  parameter int MAX_MS      = 1000,
  parameter int TRIALS      = 8,
  localparam int RES_W      = $clog2(MAX_MS + 2)
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startBtn,
  input  logic             stopBtn,
  input  logic             clearBtn,
  output logic             stimulusLed,
  output logic [RES_W-1:0] resultMs,
  output logic             falseStart,
  output logic [RES_W-1:0] averageMs,
  output logic             averageValid
);

  rtStrobe_t strobe;
  rtStatus_t status;

  rt_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .startBtn    (startBtn),
    .stopBtn     (stopBtn),
    .clearBtn    (clearBtn),
    .status      (status),
    .strobe      (strobe),
    .stimulusLed (stimulusLed)
  );

  rt_datapath #(
    .TICK_DIV    (TICK_DIV),
    .MIN_WAIT_MS (MIN_WAIT_MS),
    .SPAN_MS     (SPAN_MS),
    .MAX_MS      (MAX_MS),
    .TRIALS      (TRIALS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .status       (status),
    .resultMs     (resultMs),
    .falseStart   (falseStart),
    .averageMs    (averageMs),
    .averageValid (averageValid)
  );

endmodule

// File: tb/reaction_timer_tb.sv
module reaction_timer_tb;

  localparam int TD     = 4;
  localparam int MINW   = 10;
  localparam int SPAN   = 90;
  localparam int MAXMS  = 1000;
  localparam int TRIALS = 8;
  localparam int RES_W  = $clog2(MAXMS + 2);
  localparam int ERRCODE = (1 << RES_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startBtn = 1'b0, stopBtn = 1'b0, clearBtn = 1'b0;
  logic stimulusLed, falseStart, averageValid;
  logic [RES_W-1:0] resultMs, averageMs;

  int vecCount = 0;
  int missCount = 0;
  int expQ[$];
  int trialSum = 0;
  int trialCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reaction_timer #(
    .TICK_DIV(TD), .MIN_WAIT_MS(MINW), .SPAN_MS(SPAN),
    .MAX_MS(MAXMS), .TRIALS(TRIALS)
  ) u_dut (
    .clk(clk), .rstN(rstN), .startBtn(startBtn), .stopBtn(stopBtn),
    .clearBtn(clearBtn), .stimulusLed(stimulusLed), .resultMs(resultMs),
    .falseStart(falseStart), .averageMs(averageMs), .averageValid(averageValid)
  );

  task automatic chk(string req, int act, int expv);
    vecCount++;
    if (act != expv) begin
      missCount++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
    end
  endtask

  task automatic record(int v);
    trialSum += v;
    trialCnt++;
    if (trialCnt == TRIALS) begin
      expQ.push_back(trialSum / TRIALS);
      trialSum = 0;
      trialCnt = 0;
    end
  endtask

  task automatic pulseStop();
    stopBtn = 1'b1; @(negedge clk); stopBtn = 1'b0;
  endtask

  task automatic pulseClear();
    clearBtn = 1'b1; @(negedge clk); clearBtn = 1'b0;
    trialSum = 0; trialCnt = 0;
  endtask

  // press start and wait for stimulus; checks R2 and R3
  task automatic startAndWait();
    int cnt;
    int dly;
    startBtn = 1'b1; @(negedge clk); startBtn = 1'b0;
    cnt = 1;
    chk("R2 result cleared on start", int'(resultMs), 0);
    while (!stimulusLed && cnt < 20000) begin
      @(negedge clk); cnt++;
    end
    dly = (cnt - 1) / TD;
    chk("R3 wait is whole ms", (cnt - 1) % TD, 0);
    chk("R3 wait in window", int'(dly >= MINW && dly <= MINW + SPAN), 1);
  endtask

  // one trial; k = ms at stop, sat = let it saturate
  task automatic runTrial(int k, bit sat, bit poke);
    int n;
    startAndWait();
    if (sat) begin
      n = 0;
      while (stimulusLed && n < 10000) begin
        @(negedge clk); n++;
      end
      chk("R6 saturation instant", n, MAXMS * TD);
      chk("R6 saturated result", int'(resultMs), MAXMS);
      record(MAXMS);
    end else begin
      if (poke) startBtn = 1'b1;
      @(negedge clk); startBtn = 1'b0;
      repeat (k * TD) @(negedge clk);
      if (poke) chk("R2 start ignored while timing", int'(stimulusLed), 1);
      pulseStop();
      chk("R4 captured ms", int'(resultMs), k);
      chk("R4 led off after stop", int'(stimulusLed), 0);
      record(k);
    end
    repeat (3) @(negedge clk);
  endtask

  // scoreboard monitor for averages (R7)
  always @(negedge clk) begin
    if (rstN && averageValid) begin
      if (expQ.size() == 0) chk("R7 unexpected average strobe", 1, 0);
      else chk("R7 average value", int'(averageMs), expQ.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      missCount++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 led off", int'(stimulusLed), 0);
    chk("R1 result zero", int'(resultMs), 0);
    chk("R1 false flag", int'(falseStart), 0);
    chk("R1 average zero", int'(averageMs), 0);
    chk("R1 strobe low", int'(averageValid), 0);

    pulseStop();
    chk("R4 stop in idle ignored", int'(resultMs), 0);

    runTrial(5, 1'b0, 1'b0);
    runTrial(12, 1'b0, 1'b1);
    pulseStop();
    chk("R4 stop in idle keeps result", int'(resultMs), 12);

    // false start R5
    startBtn = 1'b1; @(negedge clk); startBtn = 1'b0;
    repeat (2) @(negedge clk);
    pulseStop();
    chk("R5 flag set", int'(falseStart), 1);
    chk("R5 error code", int'(resultMs), ERRCODE);
    startBtn = 1'b1; @(negedge clk); startBtn = 1'b0;
    repeat (TD * (MINW + SPAN) + 10) @(negedge clk);
    chk("R5 start ignored, led off", int'(stimulusLed), 0);
    chk("R5 flag persists", int'(falseStart), 1);
    chk("R5 code persists", int'(resultMs), ERRCODE);
    pulseClear();
    chk("R8 clear flag", int'(falseStart), 0);
    chk("R8 clear result", int'(resultMs), 0);
    chk("R8 clear led", int'(stimulusLed), 0);

    // clear during stimulus R8
    startAndWait();
    repeat (TD * 3) @(negedge clk);
    pulseClear();
    chk("R8 clear during stimulus led", int'(stimulusLed), 0);
    chk("R8 clear during stimulus result", int'(resultMs), 0);
    repeat (3) @(negedge clk);

    // full set: 0+3+7+20+45+1000+99+150 = 1324 -> 165 (R7)
    runTrial(0, 1'b0, 1'b0);
    runTrial(3, 1'b0, 1'b0);
    runTrial(7, 1'b0, 1'b0);
    runTrial(20, 1'b0, 1'b0);
    runTrial(45, 1'b0, 1'b0);
    runTrial(0, 1'b1, 1'b0);
    runTrial(99, 1'b0, 1'b0);
    runTrial(150, 1'b0, 1'b0);
    chk("R7 first average held", int'(averageMs), 165);

    // second set: sum 37 -> 4 (R7 restart)
    runTrial(1, 1'b0, 1'b0);
    runTrial(2, 1'b0, 1'b0);
    runTrial(3, 1'b0, 1'b0);
    runTrial(4, 1'b0, 1'b0);
    runTrial(5, 1'b0, 1'b0);
    runTrial(6, 1'b0, 1'b0);
    runTrial(7, 1'b0, 1'b0);
    runTrial(9, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk("R7 second average held", int'(averageMs), 4);
    chk("R7 all averages seen", expQ.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule